// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Postscaler

This block is a free-running watchdog. A slow timebase, brought in as a one-cycle `tick` strobe, advances a base counter. That counter emits a base-period pulse once every 256 ticks. The base-period pulses feed a postscaler whose ratio is a power of two, picked by a 3-bit select code. When the postscaler reaches the chosen ratio, the block raises a single-cycle request to reset the device. This lets the system recover from a program that has stopped servicing the watchdog.

Two inputs decide whether the watchdog runs. A hard enable, normally driven from a configuration fuse, forces the watchdog on whatever software does. While the hard enable is low, a software enable bit turns the watchdog on or off. Firmware keeps the watchdog quiet by pulsing `kick` before the period runs out. A kick clears both counters.

Top module: `wdog_postscaled`

## Requirements
- R1: The timeout is 256 × 2^`ps_sel` ticks counted from a restart. `ps_sel` = 0 gives 1:1, 1 gives 1:2, and so on, with each code doubling the ratio up to 7, which gives 1:128.
- R2: While `hw_force_en` = 1, the watchdog counts and times out whatever the value of `sw_en`.
- R3: While `hw_force_en` = 0, the watchdog runs only while `sw_en` = 1. With both inputs low, `wdt_rst_req` never asserts.
- R4: While the watchdog is disabled, both counters are held at zero. After it is enabled, a full timeout period elapses before a request.
- R5: A `kick` clears the base counter and the postscaler in the same cycle. A fresh full period then starts.
- R6: A `kick` in the same cycle as the final tick of a period suppresses that request. A fresh full period then starts.
- R7: `wdt_rst_req` goes high in the cycle after the edge that samples the final tick. It stays high for exactly one cycle. The counters restart from zero, so the next request follows a full period later.
- R8: A change to `ps_sel` while the watchdog runs has no effect until the next kick, timeout or disable. The select is also captured in the first cycle after reset.
- R9: After reset, `wdt_rst_req` is 0 and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe from the slow timebase |
| hw_force_en | input | 1 | Hard enable; 1 forces the watchdog on |
| sw_en | input | 1 | Software enable, used while hw_force_en is 0 |
| ps_sel | input | 3 | Postscale code; ratio is 2^ps_sel |
| kick | input | 1 | Clear strobe that restarts both counters |
| wdt_rst_req | output | 1 | One-cycle device reset request |

## Verification
The bench counts ticks to the exact edge for the shortest and longest ratios and for one ratio in between. A counter with an off-by-one error would fire one tick early or late, and a wrong decode would land on another power of two. It also places a kick on the very tick that would time out. A design that let the overflow win would issue a reset that firmware had just prevented. Further tests change the select in the middle of a period and enable the watchdog after a long disabled stretch. A design that applied the select at once, or kept counting while disabled, would time out early.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W = 3;
  localparam int PS_W  = (1 << SEL_W);

  typedef logic [SEL_W-1:0] ps_sel_t;
  typedef logic [PS_W-1:0]  ps_cnt_t;

  // Ratio for a select code: a one-hot value with the bit at position sel set.
  function automatic ps_cnt_t ps_ratio(input ps_sel_t sel);
    ps_cnt_t r;
    r      = '0;
    r[sel] = 1'b1;
    return r;
  endfunction

  // True when the next base pulse completes the selected ratio.
  function automatic logic ps_last(input ps_cnt_t cnt, input ps_sel_t sel);
    return (cnt + ps_cnt_t'(1)) == ps_ratio(sel);
  endfunction
endpackage

// File: rtl/wdog_enable_arb.sv
module wdog_enable_arb (
  input  logic hw_force_en,
  input  logic sw_en,
  output logic active
);
  // The hard enable wins; software decides only when the hard enable is clear.
  always_comb begin
    if (hw_force_en) active = 1'b1;
    else             active = sw_en;
  end
endmodule

// File: rtl/wdog_base_cnt.sv
module wdog_base_cnt #(
  parameter int BASE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  input  logic tick,
  output logic base_pulse,
  output logic cnt_zero
);
  localparam logic [BASE_W-1:0] CNT_MAX = '1;

  logic [BASE_W-1:0] cnt;

  assign base_pulse = active && tick && (cnt == CNT_MAX);
  assign cnt_zero   = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!active || restart) cnt <= '0;
    else if (tick)              cnt <= cnt + 1'b1;
  end

  AST_BASE_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt_zero); // R4
endmodule

// File: rtl/wdog_postscaler.sv
module wdog_postscaler
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    active,
  input  logic    kick,
  input  logic    base_pulse,
  input  ps_sel_t sel_in,
  output logic    ovf,
  output logic    ps_zero
);
  ps_cnt_t ps_cnt;
  ps_sel_t sel_q;
  logic    primed;
  logic    load_sel;

  assign ovf      = base_pulse && !kick && ps_last(ps_cnt, sel_q);
  assign ps_zero  = (ps_cnt == '0);
  assign load_sel = !primed || !active || kick || ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      primed <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (load_sel) sel_q <= sel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ps_cnt <= '0;
    else if (!active || kick || ovf) ps_cnt <= '0;
    else if (base_pulse)            ps_cnt <= ps_cnt + ps_cnt_t'(1);
  end

  AST_SEL_HELD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && active && !kick && !ovf) |=> $stable(sel_q)); // R8
  AST_PS_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> ps_zero); // R4
endmodule

// File: rtl/wdog_postscaled.sv
module wdog_postscaled
  import wdog_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hw_force_en,
  input  logic             sw_en,
  input  logic [SEL_W-1:0] ps_sel,
  input  logic             kick,
  output logic             wdt_rst_req
);
  logic active;
  logic base_pulse;
  logic ovf_evt;
  logic restart;
  logic base_zero;
  logic ps_zero;

  wdog_enable_arb u_arb (
    .hw_force_en (hw_force_en),
    .sw_en       (sw_en),
    .active      (active)
  );

  assign restart = kick || ovf_evt;

  wdog_base_cnt #(.BASE_W(BASE_W)) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .restart    (restart),
    .tick       (tick),
    .base_pulse (base_pulse),
    .cnt_zero   (base_zero)
  );

  wdog_postscaler u_ps (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .kick       (kick),
    .base_pulse (base_pulse),
    .sel_in     (ps_sel),
    .ovf        (ovf_evt),
    .ps_zero    (ps_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_rst_req <= 1'b0;
    else        wdt_rst_req <= ovf_evt;
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req); // R7
  AST_REQ_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> (base_zero && ps_zero)); // R7
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (base_zero && ps_zero)); // R5
  AST_KICK_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !wdt_rst_req); // R6
  AST_FORCED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_force_en && tick && !kick) |=> (!base_zero || !ps_zero || wdt_rst_req)); // R2
  AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_force_en && !sw_en) |=> !wdt_rst_req); // R3
endmodule

// File: tb/sim_wdog_postscaled.sv
module sim_wdog_postscaled;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       hw_force_en = 1'b0;
  logic       sw_en = 1'b0;
  logic [2:0] ps_sel = 3'd0;
  logic       kick = 1'b0;
  logic       wdt_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_postscaled u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hw_force_en(hw_force_en),
    .sw_en(sw_en), .ps_sel(ps_sel), .kick(kick), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wdt_rst_req=%0b expected %0b", req, act, exp);
    end
  endtask

  function automatic int period(input int sel);
    return 256 * (2 ** sel);
  endfunction

  // Apply n consecutive ticks; returns 1 if a request was seen before the last edge.
  task automatic run_ticks(input int n, output bit seen);
    seen = 1'b0;
    @(negedge clk);
    tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (wdt_rst_req) seen = 1'b1;
    end
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_kick();
    @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // Disable, set the select and enable through the chosen route.
  task automatic arm(input logic hw, input logic sw, input logic [2:0] sel);
    @(negedge clk);
    hw_force_en = 1'b0; sw_en = 1'b0; ps_sel = sel;
    @(negedge clk);
    hw_force_en = hw; sw_en = sw;
  endtask

  // One exact period: silent for n-1 ticks, request on the n-th.
  task automatic expect_period(input string req, input int n);
    bit seen;
    run_ticks(n - 1, seen);
    check(req, seen, 1'b0);
    run_ticks(1, seen);
    check(req, wdt_rst_req, 1'b1);
    @(negedge clk);
    check({req, " single cycle"}, wdt_rst_req, 1'b0);
  endtask

  task automatic t_reset();
    idle(1);
    check("R9", wdt_rst_req, 1'b0);
  endtask

  task automatic t_ratios();
    arm(1'b1, 1'b0, 3'd0);
    expect_period("R1 sel0", period(0));
    expect_period("R7 restart", period(0));
    arm(1'b0, 1'b1, 3'd3);
    expect_period("R1 sel3", period(3));
    arm(1'b1, 1'b0, 3'd7);
    expect_period("R1 sel7", period(7));
  endtask

  task automatic t_enable();
    bit seen;
    arm(1'b0, 1'b0, 3'd0);
    run_ticks(1000, seen);
    check("R3 off", seen, 1'b0);
    @(negedge clk); sw_en = 1'b1;
    expect_period("R4 full period after enable", period(0));
    @(negedge clk); hw_force_en = 1'b1; sw_en = 1'b0;
    expect_period("R2 forced", period(0));
  endtask

  task automatic t_kick();
    bit seen;
    arm(1'b1, 1'b0, 3'd1);
    run_ticks(300, seen);
    do_kick();
    expect_period("R5 kick", period(1));
    run_ticks(period(1) - 1, seen);
    @(negedge clk);
    tick = 1'b1; kick = 1'b1;
    @(negedge clk);
    tick = 1'b0; kick = 1'b0;
    check("R6 suppressed", wdt_rst_req, 1'b0);
    expect_period("R6 fresh period", period(1));
  endtask

  task automatic t_sel_change();
    bit seen;
    arm(1'b0, 1'b1, 3'd0);
    run_ticks(100, seen);
    @(negedge clk); ps_sel = 3'd1;
    expect_period("R8 old ratio", period(0) - 100);
    expect_period("R8 new ratio", period(1));
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_ratios();
    t_enable();
    t_kick();
    t_sel_change();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, done=%0b expected 1", done);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule